// File: doc/BRIEF.md
# DRAM Open-Row Access Controller

This block runs single-word read and write accesses against a conventional asynchronous DRAM. A requester presents a byte address, a write flag, write data and an area select through a valid/ready handshake. The controller turns the byte address into a word address and cuts it into a column field and a row field. The column width comes from a three-bit code in the configuration. Both fields go out in turn on one multiplexed address bus, under active-low RAS and CAS strobes. A one-cycle done pulse marks the end of each access, and for a read it carries the captured data.

An optional row-hold mode keeps RAS low after an access to the hold-capable area, so the row stays open. A later request to that same row then starts at the column phase. A request to any other row, or to the other area, first precharges for a fixed number of cycles. An idle-close input lets the surrounding logic shut an open row before it uses the bus for some other device. Column-width codes with the top bit set are rejected: the block raises an error flag and takes no request until a valid code returns.

Top module: `dram_row_ctrl`

## Requirements
- R1: After reset, ras_n, cas_n and we_n are high, done is low and no row counts as open.
- R2: The word address is the byte address shifted right by one. Code 0, 1, 2 or 3 gives a column width W of 8, 9, 10 or 11 bits. In the column and CAS cycles, ma carries the low W bits of the word address. In the row cycle, ma carries the 12 word-address bits just above them.
- R3: An access that opens a row has one row-address cycle with RAS high, then one column-address cycle with RAS low and CAS high, then two cycles with CAS low. done is high for exactly the next cycle, which comes 4 cycles after the accepting edge.
- R4: When cfg_hold is 0, or the access went to area 0, ras_n is high in the cycle after the access ends.
- R5: When cfg_hold is 1 and the access went to area 1, ras_n stays low after the access ends, and that row counts as open.
- R6: A request to area 1 whose row equals the open row skips the row phase. It goes straight to the column cycle, and done comes 3 cycles after the accepting edge.
- R7: A request that meets an open row and is not a hit (a different row, or area 0) holds RAS high for 2 precharge cycles. Then it runs a full row-opening access, and done comes 6 cycles after the accepting edge.
- R8: While cfg_colw[2] is 1, cfg_err is 1 and req_ready is 0. No request is accepted and no strobe moves until a valid code is loaded.
- R9: idle_close asserted while the block is idle closes the open row, and ras_n is high in the next cycle. When it arrives together with an accepted request to the open row, the request takes the precharge path, not the hit path.
- R10: For a write, we_n is low and dq_oe is high in exactly the two CAS-low cycles, with dq_out equal to the write data. we_n is high in every other cycle.
- R11: For a read, rd_data shown with done equals dq_in as sampled in the last CAS-low cycle.
- R12: cas_n is never low while ras_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_colw | input | 3 | Column-width code; top bit set is reserved |
| cfg_hold | input | 1 | Keep the row open after accesses to area 1 |
| idle_close | input | 1 | Close any open row while idle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 24 | Byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_area | input | 1 | Target area; only area 1 may hold a row |
| req_wdata | input | 16 | Write data |
| ma | output | 12 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dq_out | output | 16 | Data driven toward memory |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 16 | Data from memory |
| done | output | 1 | One-cycle access completion pulse |
| rd_data | output | 16 | Captured read data |
| cfg_err | output | 1 | Reserved column-width code present |

## Verification
Two functions can land in the same idle cycle: the close command and the acceptance of a request that would otherwise hit the open row. The bench provokes this by raising idle_close in the very cycle a same-row request is accepted. It judges the outcome by the latency (6 cycles, the precharge path) and by the RAS level in each cycle. The cycle-accurate reference model in the bench gives the close priority over the hit, and every output is compared with it on every clock. So a design that honoured the stale hit shows up as a mismatch on ras_n, ma and done.

// File: rtl/dram_row_pkg.sv
package dram_row_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_PRE  = 3'd1,
      PH_ROW  = 3'd2,
      PH_COL  = 3'd3,
      PH_CAS  = 3'd4
   } dram_phase_e;

   localparam int COLW_CODES = 4;
   localparam int COLW_BASE  = 8;
   localparam int COLW_MAX   = COLW_BASE + COLW_CODES - 1;

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split
   import dram_row_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int MA_W       = 12,
   parameter int BYTE_SHIFT = 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        code,
   output logic [MA_W-1:0]   col,
   output logic [MA_W-1:0]   row,
   output logic              code_ok
);

   localparam int WORD_W = ADDR_W - BYTE_SHIFT;
   localparam int EXT_W  = WORD_W + MA_W;

   if (MA_W < COLW_MAX) begin : g_bad_ma
      $fatal(1, "address bus narrower than widest column");
   end
   if (WORD_W < COLW_MAX) begin : g_bad_addr
      $fatal(1, "word address narrower than widest column");
   end

   logic [EXT_W-1:0] word_ext;
   logic [MA_W-1:0]  col_c [COLW_CODES];
   logic [MA_W-1:0]  row_c [COLW_CODES];

   assign word_ext = {{MA_W{1'b0}}, addr[ADDR_W-1:BYTE_SHIFT]};

   for (genvar k = 0; k < COLW_CODES; k++) begin : g_width
      localparam int CW = COLW_BASE + k;
      assign col_c[k] = MA_W'(word_ext[CW-1:0]);
      assign row_c[k] = word_ext[CW +: MA_W];
   end

   assign code_ok = ~code[2];
   assign col     = col_c[code[1:0]];
   assign row     = row_c[code[1:0]];

endmodule

// File: rtl/dram_row_tracker.sv
module dram_row_tracker #(
   parameter int   MA_W      = 12,
   parameter logic HOLD_AREA = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            finish,
   input  logic            keep,
   input  logic [MA_W-1:0] fin_row,
   input  logic [MA_W-1:0] req_row,
   input  logic            req_area,
   output logic            open_valid,
   output logic            hit
);

   logic [MA_W-1:0] open_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_valid <= 1'b0;
         open_row   <= '0;
      end else if (finish) begin
         open_valid <= keep;
         open_row   <= fin_row;
      end else if (clear) begin
         open_valid <= 1'b0;
      end
   end

   assign hit = open_valid && (req_area == HOLD_AREA) && (req_row == open_row);

endmodule

// File: rtl/dram_timing_fsm.sv
module dram_timing_fsm
   import dram_row_pkg::*;
#(
   parameter int PRE_CYC = 2,
   parameter int CAS_CYC = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go_col,
   input  logic        go_pre,
   input  logic        go_row,
   output dram_phase_e phase,
   output logic        finish
);

   localparam int LONGEST = (PRE_CYC > CAS_CYC) ? PRE_CYC : CAS_CYC;
   localparam int CNT_W   = $clog2(LONGEST + 1);

   if (PRE_CYC < 1 || CAS_CYC < 1) begin : g_bad_timing
      $fatal(1, "timing counts must be at least one cycle");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (go_col) begin
                  phase <= PH_COL;
               end else if (go_pre) begin
                  phase <= PH_PRE;
                  cnt   <= CNT_W'(PRE_CYC - 1);
               end else if (go_row) begin
                  phase <= PH_ROW;
               end
            end
            PH_PRE: begin
               if (cnt == '0) phase <= PH_ROW;
               else           cnt   <= cnt - 1'b1;
            end
            PH_ROW: phase <= PH_COL;
            PH_COL: begin
               phase <= PH_CAS;
               cnt   <= CNT_W'(CAS_CYC - 1);
            end
            PH_CAS: begin
               if (cnt == '0) phase <= PH_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign finish = (phase == PH_CAS) && (cnt == '0);

endmodule

// File: rtl/dram_row_ctrl.sv
module dram_row_ctrl
   import dram_row_pkg::*;
#(
   parameter int   ADDR_W    = 24,
   parameter int   DATA_W    = 16,
   parameter int   MA_W      = 12,
   parameter int   PRE_CYC   = 2,
   parameter int   CAS_CYC   = 2,
   parameter logic HOLD_AREA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_colw,
   input  logic              cfg_hold,
   input  logic              idle_close,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_we,
   input  logic              req_area,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [MA_W-1:0]   ma,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   input  logic [DATA_W-1:0] dq_in,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              cfg_err
);

   localparam int BYTE_SHIFT = $clog2(DATA_W / 8);

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
      $fatal(1, "data width must be a whole number of bytes");
   end

   logic [MA_W-1:0]   split_col, split_row;
   logic              code_ok;
   logic              open_valid, row_hit, hit_eff;
   logic              accept, finish, tracker_clear, keep_row;
   dram_phase_e       phase;
   logic [MA_W-1:0]   row_q, col_q;
   logic              we_q, area_q;
   logic [DATA_W-1:0] wd_q;
   logic              in_idle, in_cas, col_side;

   dram_addr_split #(
      .ADDR_W     (ADDR_W),
      .MA_W       (MA_W),
      .BYTE_SHIFT (BYTE_SHIFT)
   ) u_split (
      .addr    (req_addr),
      .code    (cfg_colw),
      .col     (split_col),
      .row     (split_row),
      .code_ok (code_ok)
   );

   assign in_idle  = (phase == PH_IDLE);
   assign in_cas   = (phase == PH_CAS);
   assign col_side = (phase == PH_COL) || in_cas;

   assign req_ready     = in_idle && code_ok;
   assign cfg_err       = ~code_ok;
   assign accept        = req_valid && req_ready;
   assign hit_eff       = row_hit && !idle_close;
   assign tracker_clear = (in_idle && idle_close) || (accept && !hit_eff);
   assign keep_row      = cfg_hold && (area_q == HOLD_AREA);

   dram_row_tracker #(
      .MA_W      (MA_W),
      .HOLD_AREA (HOLD_AREA)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (tracker_clear),
      .finish     (finish),
      .keep       (keep_row),
      .fin_row    (row_q),
      .req_row    (split_row),
      .req_area   (req_area),
      .open_valid (open_valid),
      .hit        (row_hit)
   );

   dram_timing_fsm #(
      .PRE_CYC (PRE_CYC),
      .CAS_CYC (CAS_CYC)
   ) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_col (accept && hit_eff),
      .go_pre (accept && !hit_eff && open_valid),
      .go_row (accept && !hit_eff && !open_valid),
      .phase  (phase),
      .finish (finish)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q  <= '0;
         col_q  <= '0;
         we_q   <= 1'b0;
         area_q <= 1'b0;
         wd_q   <= '0;
      end else if (accept) begin
         row_q  <= split_row;
         col_q  <= split_col;
         we_q   <= req_we;
         area_q <= req_area;
         wd_q   <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done    <= 1'b0;
         rd_data <= '0;
      end else begin
         done <= finish;
         if (finish && !we_q) rd_data <= dq_in;
      end
   end

   always_comb begin
      if (in_idle) ras_n = ~open_valid;
      else         ras_n = (phase == PH_PRE) || (phase == PH_ROW);
   end

   assign cas_n  = ~in_cas;
   assign dq_oe  = in_cas && we_q;
   assign we_n   = ~dq_oe;
   assign dq_out = wd_q;
   assign ma     = col_side ? col_q : row_q;

endmodule

// File: rtl/dram_row_ctrl_chk.sv
module dram_row_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic ras_n,
   input logic cas_n,
   input logic we_n,
   input logic dq_oe,
   input logic done,
   input logic req_ready,
   input logic cfg_err,
   input logic idle_close
);

   assert_cas_needs_ras_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   assert_we_inside_cas_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!cas_n && dq_oe));

   assert_err_blocks_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !req_ready);

   assert_cas_two_cycles_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |=> !cas_n);

   assert_done_after_cas_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cas_n && $past(!cas_n)));

   assert_close_drops_ras_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && idle_close) |=> ras_n);

endmodule

bind dram_row_ctrl dram_row_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ras_n      (ras_n),
   .cas_n      (cas_n),
   .we_n       (we_n),
   .dq_oe      (dq_oe),
   .done       (done),
   .req_ready  (req_ready),
   .cfg_err    (cfg_err),
   .idle_close (idle_close)
);

// File: tb/tb_dram_row_ctrl.sv
`timescale 1ns/1ps
module tb_dram_row_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_colw = 3'd0;
   logic        cfg_hold = 1'b0;
   logic        idle_close = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_addr = '0;
   logic        req_we = 1'b0;
   logic        req_area = 1'b0;
   logic [15:0] req_wdata = '0;
   logic [11:0] ma;
   logic        ras_n, cas_n, we_n, dq_oe, done, cfg_err;
   logic [15:0] dq_out, rd_data;
   logic [15:0] dq_in = 16'h0;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit running = 1'b0;

   dram_row_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_colw(cfg_colw), .cfg_hold(cfg_hold),
      .idle_close(idle_close), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_we(req_we), .req_area(req_area),
      .req_wdata(req_wdata), .ma(ma), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
      .done(done), .rd_data(rd_data), .cfg_err(cfg_err)
   );

   always #5 clk = ~clk;

   always @(negedge clk) dq_in <= dq_in + 16'h1357;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // reference model: phases 0 idle, 1 precharge, 2 row, 3 column, 4 cas
   int          m_ph = 0, m_left = 0;
   bit          m_open = 0, m_done = 0, m_we = 0, m_ar = 0;
   int          m_row = 0, m_rq = 0, m_col = 0;
   logic [15:0] m_wd = 0, m_rd = 0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_open = 0; m_done = 0; m_rd = 0;
      end else begin
         m_done = 0;
         case (m_ph)
            0: begin
               if (req_valid && !cfg_colw[2]) begin
                  int w, wa;
                  w     = 8 + int'(cfg_colw[1:0]);
                  wa    = int'(req_addr) >> 1;
                  m_col = wa & ((1 << w) - 1);
                  m_rq  = (wa >> w) & 4095;
                  m_we  = req_we; m_wd = req_wdata; m_ar = req_area;
                  if (m_open && !idle_close && req_area && m_rq == m_row) m_ph = 3;
                  else if (m_open) begin m_ph = 1; m_left = 2; m_open = 0; end
                  else m_ph = 2;
               end
               if (idle_close) m_open = 0;
            end
            1: begin m_left--; if (m_left == 0) m_ph = 2; end
            2: m_ph = 3;
            3: begin m_ph = 4; m_left = 2; end
            default: begin
               m_left--;
               if (m_left == 0) begin
                  m_ph = 0; m_done = 1;
                  if (!m_we) m_rd = dq_in;
                  m_open = cfg_hold && m_ar;
                  m_row  = m_rq;
               end
            end
         endcase
      end
   end

   always @(posedge clk) begin
      #2;
      if (running && rst_n) begin
         bit e_ras, e_oe;
         e_ras = (m_ph == 0) ? !m_open : (m_ph == 1 || m_ph == 2);
         e_oe  = (m_ph == 4) && m_we;
         if (m_ph == 0) chk(m_open ? "R5 ras_n held open" : "R4 ras_n released", ras_n, e_ras);
         else if (m_ph == 1) chk("R7 ras_n precharge", ras_n, e_ras);
         else chk("R3 ras_n", ras_n, e_ras);
         chk("R3 cas_n", cas_n, m_ph != 4);
         chk("R10 we_n", we_n, !e_oe);
         chk("R10 dq_oe", dq_oe, e_oe);
         if (e_oe) chk("R10 dq_out", dq_out, m_wd);
         chk("R3 done", done, m_done);
         if (m_done) chk("R11 rd_data", rd_data, m_rd);
         chk("R8 req_ready", req_ready, (m_ph == 0) && !cfg_colw[2]);
         chk("R8 cfg_err", cfg_err, cfg_colw[2]);
         if (m_ph == 2) chk("R2 ma row", ma, m_rq);
         if (m_ph == 3 || m_ph == 4) chk("R2 ma col", ma, m_col);
         if (!cas_n && ras_n) chk("R12 cas under ras", 1, 0);
      end
   end

   task automatic do_req(input logic [23:0] a, input bit w, input bit ar,
                         input logic [15:0] d, input bit cls, input int exp_lat,
                         input string tag);
      int n;
      @(negedge clk);
      req_valid = 1; req_addr = a; req_we = w; req_area = ar; req_wdata = d;
      idle_close = cls;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      #1;
      req_valid = 0; idle_close = 0;
      n = 0;
      while (n < 50) begin
         @(posedge clk); n++; #3;
         if (done) break;
      end
      chk(tag, n, exp_lat);
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ras_n reset", ras_n, 1);
      chk("R1 cas_n reset", cas_n, 1);
      chk("R1 we_n reset", we_n, 1);
      chk("R1 done reset", done, 0);
      rst_n = 1;
      running = 1;
      idle(2);
      chk("R1 no open row", ras_n, 1);

      // closed-row accesses, every width code
      cfg_hold = 0; cfg_colw = 3'd0;
      do_req(24'h012345, 1, 1, 16'hA5C3, 0, 4, "R3 closed write latency");
      do_req(24'h012345, 0, 1, 16'h0, 0, 4, "R4 closed read latency");
      cfg_colw = 3'd1; do_req(24'hABCDEF, 0, 1, 16'h0, 0, 4, "R2 width9 latency");
      cfg_colw = 3'd2; do_req(24'h5A5A5A, 1, 0, 16'h1234, 0, 4, "R2 width10 latency");
      cfg_colw = 3'd3; do_req(24'hFFFFFE, 0, 1, 16'h0, 0, 4, "R2 width11 latency");

      // open-row mode on area 1, width 10: word bits above 10 form the row
      cfg_colw = 3'd2; cfg_hold = 1;
      do_req(24'h100010, 0, 1, 16'h0, 0, 4, "R5 first open latency");
      idle(2);
      chk("R5 row kept open", ras_n, 0);
      do_req(24'h1007FE, 0, 1, 16'h0, 0, 3, "R6 hit latency");
      do_req(24'h100100, 1, 1, 16'hBEEF, 0, 3, "R6 hit write latency");
      do_req(24'h200000, 0, 1, 16'h0, 0, 6, "R7 miss latency");
      do_req(24'h200004, 0, 0, 16'h0, 0, 6, "R7 other area precharge");
      idle(1);
      chk("R4 area0 closes row", ras_n, 1);
      do_req(24'h200004, 0, 0, 16'h0, 0, 4, "R4 area0 fresh row");

      // idle close alone, then close racing with a hit
      do_req(24'h300000, 0, 1, 16'h0, 0, 4, "R5 open again");
      @(negedge clk); idle_close = 1;
      @(negedge clk); idle_close = 0;
      chk("R9 close drops ras", ras_n, 1);
      do_req(24'h300002, 0, 1, 16'h0, 0, 4, "R9 after close fresh row");
      do_req(24'h300006, 0, 1, 16'h0, 1, 6, "R9 close beats hit");

      // reserved codes
      for (int c = 4; c < 8; c++) begin
         cfg_colw = 3'(c);
         @(negedge clk); req_valid = 1; req_addr = 24'h000100;
         repeat (3) @(negedge clk);
         chk("R8 reserved no ready", req_ready, 0);
         chk("R8 reserved flag", cfg_err, 1);
         chk("R8 reserved no cas", cas_n, 1);
         req_valid = 0;
      end
      cfg_colw = 3'd0; cfg_hold = 0;
      do_req(24'h000100, 0, 1, 16'h0, 0, 6, "R8 valid code resumes");
      do_req(24'h000100, 0, 1, 16'h0, 0, 4, "R8 closed after resume");
      idle(3);

      running = 0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL R3 watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule